// File: doc/BRIEF.md
# Keyed Flash Bank Lock Register

This block holds the write-protection state of a flash array split into a low space, a mid space, a shadow sector and a high space. A lock bit at 1 shields its bank from program and erase, and a bank is released by writing 0 into its bit. There are three lock registers: a primary and a secondary register for the low, mid and shadow banks, and a separate register for the high banks. A program/erase engine reads the resulting lock vectors straight from the block's outputs.

Every register comes out of reset protected: its enable status bit reads 0, and ordinary writes to it are discarded. Software first writes the register's own 32-bit key word to it. That sets the enable bit. From then on, each write to the register replaces its lock fields. The enable bit is read-only and sticky, so only reset clears it. For the low, mid and shadow banks, the engine sees the bitwise OR of the primary and secondary registers. Such a bank therefore counts as unlocked only when both registers release it. The register bus is a plain single-cycle interface: writes take effect at the clock edge and reads are combinational.

Top module: `flash_lock_regs`

## Requirements
- R1: After reset, every lock bit in all three registers is 1, every enable bit reads 0, and every lock output is all ones.
- R2: The primary register (address 0) sets its enable bit only when the word 0xA1A11111 is written to it while it is disabled.
- R3: The secondary register (address 1) sets its enable bit only when the word 0xC3C33333 is written to it while it is disabled.
- R4: The high register (address 2) sets its enable bit only when the word 0xB2B22222 is written to it while it is disabled.
- R5: While a register is disabled, any write of a value other than its own key changes nothing. This includes a write of another register's key. The register reads back all-ones locks with enable 0.
- R6: Read layout of the primary and secondary registers: enable at bit 31, low locks at bits 5:0, mid locks at bits 17:16, shadow lock at bit 20. Read layout of the high register: enable at bit 31, high locks at bits 19:0. All other bits read 0.
- R7: Once a register is enabled, every write to it loads its lock fields from the same bit positions, including a write of its key. The enable bit stays 1 whatever bit 31 of the written word holds.
- R8: The low, mid and shadow lock outputs are the bitwise OR of the primary and secondary fields. The high lock output equals the high register's field.
- R9: Address 3 reads as zero, and writes to it affect no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| low_locked | output | LOW_BANKS | Low-space lock vector, 1 = protected |
| mid_locked | output | MID_BANKS | Mid-space lock vector |
| shadow_locked | output | 1 | Shadow sector lock |
| high_locked | output | HIGH_BANKS | High-space lock vector |

## Verification
The assertions assume that reg_addr, reg_we and reg_wdata are stable and defined around each rising edge. They also assume one write per cycle. With that, an enable rise can always be traced to a key write in the cycle before. The bench changes inputs only on falling edges and holds the strobe for exactly one cycle. Reads are taken with the strobe low, so every write sweep, including the single-bit-flipped keys and the foreign keys, lands in exactly one cycle that the model can account for.

// File: rtl/flash_lock_regs.sv
module flash_lock_regs #(
  parameter int LOW_BANKS  = 6,
  parameter int MID_BANKS  = 2,
  parameter int HIGH_BANKS = 20,
  parameter logic [31:0] KEY_PRI  = 32'hA1A1_1111,
  parameter logic [31:0] KEY_SEC  = 32'hC3C3_3333,
  parameter logic [31:0] KEY_HIGH = 32'hB2B2_2222
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic                  reg_we,
  output logic [31:0]           reg_rdata,
  output logic [LOW_BANKS-1:0]  low_locked,
  output logic [MID_BANKS-1:0]  mid_locked,
  output logic                  shadow_locked,
  output logic [HIGH_BANKS-1:0] high_locked
);
  localparam int MID_LSB = 16;
  localparam int SH_BIT  = 20;
  localparam int EN_BIT  = 31;
  localparam logic [1:0][31:0] LM_KEY = {KEY_SEC, KEY_PRI};

  logic [1:0]                 lm_en;
  logic [1:0][LOW_BANKS-1:0]  lm_low;
  logic [1:0][MID_BANKS-1:0]  lm_mid;
  logic [1:0]                 lm_sh;
  logic                       hi_en;
  logic [HIGH_BANKS-1:0]      hi_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lm_en   <= '0;
      lm_low  <= '1;
      lm_mid  <= '1;
      lm_sh   <= '1;
      hi_en   <= 1'b0;
      hi_lock <= '1;
    end else if (reg_we) begin
      for (int i = 0; i < 2; i++) begin
        if (reg_addr == 2'(i)) begin
          if (!lm_en[i]) begin
            if (reg_wdata == LM_KEY[i]) lm_en[i] <= 1'b1;
          end else begin
            lm_low[i] <= reg_wdata[LOW_BANKS-1:0];
            lm_mid[i] <= reg_wdata[MID_LSB +: MID_BANKS];
            lm_sh[i]  <= reg_wdata[SH_BIT];
          end
        end
      end
      if (reg_addr == 2'd2) begin
        if (!hi_en) begin
          if (reg_wdata == KEY_HIGH) hi_en <= 1'b1;
        end else begin
          hi_lock <= reg_wdata[HIGH_BANKS-1:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0, 2'd1: begin
        reg_rdata[EN_BIT]                 = lm_en[reg_addr[0]];
        reg_rdata[LOW_BANKS-1:0]          = lm_low[reg_addr[0]];
        reg_rdata[MID_LSB +: MID_BANKS]   = lm_mid[reg_addr[0]];
        reg_rdata[SH_BIT]                 = lm_sh[reg_addr[0]];
      end
      2'd2: begin
        reg_rdata[EN_BIT]           = hi_en;
        reg_rdata[HIGH_BANKS-1:0]   = hi_lock;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign low_locked    = lm_low[0] | lm_low[1];
  assign mid_locked    = lm_mid[0] | lm_mid[1];
  assign shadow_locked = lm_sh[0] | lm_sh[1];
  assign high_locked   = hi_lock;
endmodule

// File: rtl/flash_lock_regs_chk.sv
module flash_lock_regs_chk #(
  parameter int LOW_BANKS  = 6,
  parameter int HIGH_BANKS = 20,
  parameter logic [31:0] KEY_PRI  = 32'hA1A1_1111,
  parameter logic [31:0] KEY_SEC  = 32'hC3C3_3333,
  parameter logic [31:0] KEY_HIGH = 32'hB2B2_2222
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                reg_addr,
  input logic [31:0]               reg_wdata,
  input logic                      reg_we,
  input logic [1:0]                lm_en,
  input logic [1:0][LOW_BANKS-1:0] lm_low,
  input logic                      hi_en,
  input logic [HIGH_BANKS-1:0]     hi_lock
);
  // R2
  pri_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lm_en[0]) |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata == KEY_PRI));
  // R3
  sec_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lm_en[1]) |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata == KEY_SEC));
  // R4
  high_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> $past(reg_we && reg_addr == 2'd2 && reg_wdata == KEY_HIGH));
  // R7
  pri_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_en[0] |=> lm_en[0]);
  // R7
  high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> hi_en);
  // R5
  pri_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lm_en[0] |=> $stable(lm_low[0]));
  // R5
  high_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> $stable(hi_lock));
endmodule

bind flash_lock_regs flash_lock_regs_chk #(
  .LOW_BANKS(LOW_BANKS), .HIGH_BANKS(HIGH_BANKS),
  .KEY_PRI(KEY_PRI), .KEY_SEC(KEY_SEC), .KEY_HIGH(KEY_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .lm_en(lm_en), .lm_low(lm_low), .hi_en(hi_en), .hi_lock(hi_lock)
);

// File: tb/tb_flash_lock_regs.sv
`timescale 1ns/1ps
module tb_flash_lock_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [5:0] low_locked;
  logic [1:0] mid_locked;
  logic shadow_locked;
  logic [19:0] high_locked;

  always #2.5 clk = ~clk;

  flash_lock_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .low_locked(low_locked),
    .mid_locked(mid_locked), .shadow_locked(shadow_locked), .high_locked(high_locked)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] model [4];
  logic [31:0] keys [3];
  logic [31:0] masks [3];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a != 2'd3) begin
      if (!model[a][31]) begin
        if (d == keys[a]) model[a] = 32'h8000_0000 | (model[a] & masks[a]);
      end else begin
        model[a] = 32'h8000_0000 | (d & masks[a]);
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] lm;
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #0.1;
      chk(tag, reg_rdata, model[a]);
    end
    lm = model[0] | model[1];
    chk({tag, "/R8 low"}, 32'(low_locked), 32'(lm[5:0]));
    chk({tag, "/R8 mid"}, 32'(mid_locked), 32'(lm[17:16]));
    chk({tag, "/R8 shadow"}, 32'(shadow_locked), 32'(lm[20]));
    chk({tag, "/R8 high"}, 32'(high_locked), 32'(model[2][19:0]));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    keys[0] = 32'hA1A1_1111; keys[1] = 32'hC3C3_3333; keys[2] = 32'hB2B2_2222;
    masks[0] = 32'h0013_003F; masks[1] = 32'h0013_003F; masks[2] = 32'h000F_FFFF;
    model[0] = masks[0]; model[1] = masks[1]; model[2] = masks[2]; model[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 R6 reset");

    // R5: flipped keys and foreign keys on every disabled register
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 32; b++) begin
        wr(2'(r), keys[r] ^ (32'd1 << b));
        check_all("R5 flipped key");
      end
      wr(2'(r), keys[(r + 1) % 3]);
      check_all("R5 foreign key");
      wr(2'(r), keys[(r + 2) % 3]);
      check_all("R5 foreign key");
      wr(2'(r), 32'h0000_0000);
      check_all("R5 zero write");
    end

    // R9: address 3 absorbs keys and data
    for (int r = 0; r < 3; r++) begin
      wr(2'd3, keys[r]);
      check_all("R9 unused address");
    end

    // R2 then R7 sweep on primary
    wr(2'd0, keys[0]);
    check_all("R2 primary key");
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, (32'(v) & 32'h3F) | (32'(v >> 6) << 16) | (32'(v & 1) << 20) | 32'h4E40_FF00);
      check_all("R7 R6 primary sweep");
    end
    wr(2'd0, keys[0]);
    check_all("R7 key rewrite");

    // R3 then R8 combine sweep
    wr(2'd1, keys[1]);
    check_all("R3 secondary key");
    for (int v = 0; v < 64; v++) begin
      wr(2'd0, 32'(v) | (32'(v & 3) << 16) | (32'((v >> 2) & 1) << 20));
      wr(2'd1, 32'((v * 37) & 63) | (32'((v >> 4) & 3) << 16) | (32'((v >> 3) & 1) << 20) | 32'h8000_0000);
      check_all("R8 R7 combine sweep");
    end
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    check_all("R8 all released");

    // R4 then high sweep
    wr(2'd2, keys[2]);
    check_all("R4 high key");
    for (int v = 0; v < 64; v++) begin
      wr(2'd2, 32'(v) * 32'h9E37_79B1);
      check_all("R7 R6 high sweep");
    end
    wr(2'd2, 32'h0);
    check_all("R7 high released");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule